// File: doc/BRIEF.md
# SPI EEPROM Page Write Sequencer

This block writes a run of 16-bit words into a serial EEPROM over a four-wire SPI link. A single `start` pulse hands it a word offset and a word count. It checks the request against the device size, and then it asks an external arbiter for the bus. It polls the part's status register until the part is idle. It issues a write-enable command, and then a write command that carries the opcode, the byte address and a burst of data words. The data words come from a valid/ready source.

A run is cut into bursts that never cross a page boundary. After each burst the chip is deselected and a settle time passes, then the bus is handed back. Any words that remain are sent by repeating the whole sequence: request, status poll, enable, then write. A one-cycle `done` or `error` pulse reports the outcome. The clock divider, page size, address width, retry limits and wait times are all parameters.

Top module: `spi_eeprom_page_writer`

## Requirements
- R1: A start with `count` equal to zero, with `offset` not below DEV_WORDS, or with `count` above DEV_WORDS minus `offset` raises `error` for one cycle, and `bus_req` never rises.
- R2: `bus_req` rises before any SPI activity, and CS may be asserted only while `bus_req` is high. If `bus_gnt` is not seen within GNT_TRIES polls, `bus_req` drops and `error` pulses.
- R3: Each status poll is one frame: opcode 0x05 followed by 8 bits shifted in. The part counts as ready when bit 0 of that byte is 0, and the other bits have no effect. MOSI stays low during the 8 input bits.
- R4: After STAT_TRIES status reads that all show busy, the block raises CS, drops `bus_req` and pulses `error` without sending any write frame. Between reads it waits GAP_CYC cycles and then pulses CS.
- R5: Every write frame is preceded by a separate frame that holds only the write-enable opcode 0x06.
- R6: The write opcode is 0x02. When ADDR_BITS is 8 and the first word of the burst is 128 or above, bit 3 of the opcode is set, giving 0x0A.
- R7: After the opcode comes an address field of ADDR_BITS bits. It holds twice the burst's first word index, truncated to ADDR_BITS, sent MSB first.
- R8: Each data word is taken from the source by a valid/ready handshake. It is sent as its low byte and then its high byte, each byte MSB first.
- R9: A burst ends when the byte address of the next word is a multiple of PAGE_BYTES, or when the run is complete. CS then rises, SETTLE_CYC cycles pass, and `bus_req` drops. Any remaining words start a new full sequence.
- R10: SCK idles low and toggles only while CS is asserted. MOSI changes only while SCK is low, which gives at least one half-period of DIV cycles before each rising edge. MISO is sampled while SCK is high.
- R11: After the final burst, `done` pulses for one cycle, with CS high and `bus_req` low. `done` and `error` are never high together.
- R12: After reset, CS is deasserted, SCK and MOSI are low, and `bus_req`, `busy` and `wr_ready` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Pulse that begins a run |
| offset | input | 16 | First word index of the run |
| count | input | 16 | Number of words in the run |
| wr_data | input | 16 | Data word from the source |
| wr_valid | input | 1 | Source word is valid |
| wr_ready | output | 1 | Block accepts the source word |
| bus_req | output | 1 | Request for the shared EEPROM bus |
| bus_gnt | input | 1 | Grant from the bus arbiter |
| sck | output | 1 | SPI serial clock |
| cs_n | output | 1 | SPI chip select, active low |
| mosi | output | 1 | Serial data to the part |
| miso | input | 1 | Serial data from the part |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle pulse when a run finishes |
| error | output | 1 | One-cycle pulse on rejection or timeout |

## Verification
Two events can fall on the same word: the page boundary that ends a burst and the last word of the run. Runs that start at word 2 with six words, and at word 250 with six words, make the final word end exactly on a page edge. The bench checks that each such run closes with exactly one write frame per page, one bus request per burst and a single `done` pulse, with no empty extra burst. A scoreboard holds the expected opcode, address and word for each word sent, and the model part decodes each frame against it.

// File: rtl/spi_eeprom_page_writer.sv
module spi_eeprom_page_writer #(
  parameter int ADDR_BITS  = 8,
  parameter int DEV_WORDS  = 256,
  parameter int PAGE_BYTES = 16,
  parameter int DIV        = 4,
  parameter int GNT_TRIES  = 16,
  parameter int STAT_TRIES = 8,
  parameter int GAP_CYC    = 250,
  parameter int SETTLE_CYC = 500000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [15:0] offset,
  input  logic [15:0] count,
  input  logic [15:0] wr_data,
  input  logic        wr_valid,
  output logic        wr_ready,
  output logic        bus_req,
  input  logic        bus_gnt,
  output logic        sck,
  output logic        cs_n,
  output logic        mosi,
  input  logic        miso,
  output logic        busy,
  output logic        done,
  output logic        error
);
  localparam int TMAX = (SETTLE_CYC > GAP_CYC) ? ((SETTLE_CYC > DIV) ? SETTLE_CYC : DIV)
                                               : ((GAP_CYC > DIV) ? GAP_CYC : DIV);
  localparam int TW   = $clog2(TMAX + 1);
  localparam int RMAX = (GNT_TRIES > STAT_TRIES) ? GNT_TRIES : STAT_TRIES;
  localparam int RW   = $clog2(RMAX + 1);
  localparam int PB   = $clog2(PAGE_BYTES);

  typedef enum logic [4:0] {
    S_IDLE, S_REQ, S_PREP, S_RDSR, S_STAT, S_CHK, S_GAP, S_CSP, S_SHIFT,
    S_WREN, S_WEN2, S_WOP, S_WADDR, S_WDATA, S_NEXT, S_SETTLE, S_REARM
  } st_t;

  st_t st, ret;
  logic [15:0] ofs_r, cnt_r, idx, sh;
  logic [4:0]  bits;
  logic        rx, sck_r, cs_r, req_r, done_r, err_r;
  logic [TW-1:0] tmr;
  logic [RW-1:0] tries;

  logic [15:0] word, baddr;
  logic [31:0] ofs32;
  logic        bad, a8, half;

  assign word  = ofs_r + idx;
  assign baddr = {word[14:0], 1'b0};
  assign ofs32 = {16'h0, offset};
  assign bad   = (count == 16'h0) || (ofs32 >= 32'(DEV_WORDS)) ||
                 ({16'h0, count} > 32'(DEV_WORDS) - ofs32);
  assign a8    = (ADDR_BITS == 8) && (word >= 16'd128);
  assign half  = (tmr == TW'(DIV - 1));

  assign wr_ready = (st == S_WDATA);
  assign mosi     = (st == S_SHIFT) && !rx && sh[15];
  assign busy     = (st != S_IDLE);
  assign sck      = sck_r;
  assign cs_n     = cs_r;
  assign bus_req  = req_r;
  assign done     = done_r;
  assign error    = err_r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; ret <= S_IDLE;
      ofs_r <= '0; cnt_r <= '0; idx <= '0; sh <= '0; bits <= '0;
      rx <= 1'b0; sck_r <= 1'b0; cs_r <= 1'b1; req_r <= 1'b0;
      tmr <= '0; tries <= '0; done_r <= 1'b0; err_r <= 1'b0;
    end else begin
      done_r <= 1'b0;
      err_r  <= 1'b0;
      unique case (st)
        S_IDLE: if (start) begin
          if (bad) err_r <= 1'b1;
          else begin
            ofs_r <= offset; cnt_r <= count; idx <= '0;
            req_r <= 1'b1; tries <= '0; st <= S_REQ;
          end
        end
        S_REQ: begin
          if (bus_gnt) begin
            tmr <= '0; st <= S_PREP;
          end else if (tries == RW'(GNT_TRIES - 1)) begin
            req_r <= 1'b0; err_r <= 1'b1; st <= S_IDLE;
          end else tries <= tries + 1'b1;
        end
        S_PREP: begin
          if (half) begin
            cs_r <= 1'b0; tries <= '0; st <= S_RDSR;
          end else tmr <= tmr + 1'b1;
        end
        S_RDSR: begin
          sh <= 16'h0500; bits <= 5'd8; rx <= 1'b0; tmr <= '0;
          ret <= S_STAT; st <= S_SHIFT;
        end
        S_STAT: begin
          sh <= 16'h0000; bits <= 5'd8; rx <= 1'b1; tmr <= '0;
          ret <= S_CHK; st <= S_SHIFT;
        end
        S_CHK: begin
          tmr <= '0;
          if (!sh[0]) begin
            cs_r <= 1'b1; ret <= S_WREN; st <= S_CSP;
          end else if (tries == RW'(STAT_TRIES - 1)) begin
            cs_r <= 1'b1; req_r <= 1'b0; err_r <= 1'b1; st <= S_IDLE;
          end else begin
            tries <= tries + 1'b1; st <= S_GAP;
          end
        end
        S_GAP: begin
          if (tmr == TW'(GAP_CYC - 1)) begin
            tmr <= '0; cs_r <= 1'b1; ret <= S_RDSR; st <= S_CSP;
          end else tmr <= tmr + 1'b1;
        end
        S_CSP: begin
          if (half) begin
            cs_r <= 1'b0; st <= ret;
          end else tmr <= tmr + 1'b1;
        end
        S_SHIFT: begin
          if (half) begin
            tmr <= '0;
            if (!sck_r) sck_r <= 1'b1;
            else begin
              sck_r <= 1'b0;
              sh    <= {sh[14:0], rx & miso};
              bits  <= bits - 1'b1;
              if (bits == 5'd1) st <= ret;
            end
          end else tmr <= tmr + 1'b1;
        end
        S_WREN: begin
          sh <= 16'h0600; bits <= 5'd8; rx <= 1'b0; tmr <= '0;
          ret <= S_WEN2; st <= S_SHIFT;
        end
        S_WEN2: begin
          cs_r <= 1'b1; tmr <= '0; ret <= S_WOP; st <= S_CSP;
        end
        S_WOP: begin
          sh <= {4'b0000, a8, 3'b010, 8'h00}; bits <= 5'd8; rx <= 1'b0; tmr <= '0;
          ret <= S_WADDR; st <= S_SHIFT;
        end
        S_WADDR: begin
          sh <= 16'(baddr << (16 - ADDR_BITS)); bits <= 5'(ADDR_BITS); rx <= 1'b0;
          tmr <= '0; ret <= S_WDATA; st <= S_SHIFT;
        end
        S_WDATA: if (wr_valid) begin
          sh <= {wr_data[7:0], wr_data[15:8]}; bits <= 5'd16; rx <= 1'b0; tmr <= '0;
          idx <= idx + 1'b1; ret <= S_NEXT; st <= S_SHIFT;
        end
        S_NEXT: begin
          if (idx == cnt_r || baddr[PB-1:0] == '0) begin
            cs_r <= 1'b1; tmr <= '0; st <= S_SETTLE;
          end else st <= S_WDATA;
        end
        S_SETTLE: begin
          if (tmr == TW'(SETTLE_CYC - 1)) begin
            req_r <= 1'b0;
            if (idx == cnt_r) begin
              done_r <= 1'b1; st <= S_IDLE;
            end else st <= S_REARM;
          end else tmr <= tmr + 1'b1;
        end
        S_REARM: begin
          req_r <= 1'b1; tries <= '0; st <= S_REQ;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/spi_eeprom_page_writer_chk.sv
module spi_eeprom_page_writer_chk (
  input logic clk,
  input logic rst_n,
  input logic sck,
  input logic cs_n,
  input logic mosi,
  input logic bus_req,
  input logic wr_ready,
  input logic busy,
  input logic done,
  input logic error
);
  p_mosi_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    sck |-> $stable(mosi));
  p_sck_in_frame_r10: assert property (@(posedge clk) disable iff (!rst_n)
    sck |-> !cs_n);
  p_mosi_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !mosi);
  p_cs_needs_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_n |-> bus_req);
  p_req_while_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |-> busy);
  p_ready_in_frame_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ready |-> (!cs_n && !sck));
  p_done_released_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (cs_n && !bus_req && !error));
  p_error_released_r4: assert property (@(posedge clk) disable iff (!rst_n)
    error |-> (cs_n && !bus_req));
endmodule

bind spi_eeprom_page_writer spi_eeprom_page_writer_chk chk_i (.*);

// File: tb/spi_eeprom_page_writer_tb.sv
module spi_eeprom_page_writer_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, wr_valid = 1'b0, bus_gnt = 1'b0, miso = 1'b0;
  logic [15:0] offset = '0, count = '0, wr_data = '0;
  logic wr_ready, bus_req, sck, cs_n, mosi, busy, done, error;

  always #10 clk = ~clk;

  spi_eeprom_page_writer #(.ADDR_BITS(8), .DEV_WORDS(256), .PAGE_BYTES(8), .DIV(2),
    .GNT_TRIES(16), .STAT_TRIES(8), .GAP_CYC(8), .SETTLE_CYC(20)) dut_i (.*);

  int n_chk = 0, n_fail = 0;
  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // scoreboard and data source
  logic [31:0] sb[$];
  logic [15:0] src_q[$];
  bit gnt_en = 1'b1;
  int busy_left = 0;
  int rdsr_cnt = 0, wren_cnt = 0, wr_frames = 0, frames = 0, req_rises = 0;
  int rd_mosi_bad = 0, hold_bad = 0;
  bit wren_pend = 1'b0;

  initial forever begin
    @(negedge clk);
    bus_gnt  = bus_req && gnt_en;
    wr_valid = src_q.size() > 0;
    wr_data  = (src_q.size() > 0) ? src_q[0] : 16'h0;
    @(posedge clk);
    if (wr_valid && wr_ready) void'(src_q.pop_front());
  end

  logic prev_sck = 1'b0, prev_mosi = 1'b0;
  always @(negedge clk) begin
    if (sck && prev_sck && mosi != prev_mosi) hold_bad++;
    prev_sck  = sck;
    prev_mosi = mosi;
  end

  always @(posedge bus_req) req_rises++;

  // model EEPROM
  logic [7:0] fb[$];
  logic [7:0] cur = '0;
  int bitcnt = 0;
  always @(negedge cs_n) begin
    bitcnt = 0;
    fb.delete();
  end
  always @(posedge sck) if (!cs_n) begin
    if (bitcnt >= 8 && fb[0] == 8'h05 && mosi) rd_mosi_bad++;
    cur = {cur[6:0], mosi};
    bitcnt++;
    if (bitcnt % 8 == 0) fb.push_back(cur);
  end
  always @(negedge sck) if (!cs_n) begin
    logic [7:0] stat;
    stat = (busy_left > 0) ? 8'h03 : 8'hF2;
    if (bitcnt >= 8 && bitcnt < 16 && fb[0] == 8'h05) miso = stat[15 - bitcnt];
    else miso = 1'b0;
  end
  always @(posedge cs_n) if (fb.size() > 0) begin
    frames++;
    if (fb[0] == 8'h05) begin
      rdsr_cnt++;
      if (busy_left > 0) busy_left--;
    end else if (fb[0] == 8'h06) begin
      wren_cnt++;
      wren_pend = 1'b1;
    end else begin
      wr_frames++;
      chk(wren_pend, "R5", "write frame without enable", 0, 1);
      wren_pend = 1'b0;
      chk(fb.size() >= 4 && fb.size() % 2 == 0, "R8", "frame byte count", fb.size(), 4);
      for (int k = 0; 2 * k + 3 < fb.size(); k++) begin
        logic [31:0] e;
        logic [15:0] w;
        w = {fb[2 * k + 3], fb[2 * k + 2]};
        if (sb.size() == 0) chk(0, "R9", "unexpected word", w, 0);
        else begin
          e = sb.pop_front();
          chk(fb[0] == e[31:24], "R6", "opcode", fb[0], e[31:24]);
          chk(fb[1] == e[23:16], "R7", "address", fb[1], e[23:16]);
          chk(w == e[15:0], "R8", "data word", w, e[15:0]);
        end
      end
    end
  end

  task automatic clear_stats();
    rdsr_cnt = 0; wren_cnt = 0; wr_frames = 0; frames = 0; req_rises = 0;
    rd_mosi_bad = 0; hold_bad = 0;
  endtask

  task automatic run(input int o, input int c, input bit ok, output bit got_done, output bit got_err);
    int start_w;
    clear_stats();
    if (ok) begin
      start_w = o;
      for (int i = 0; i < c; i++) begin
        logic [15:0] d;
        logic [7:0] op;
        d  = 16'(16'h1234 + i * 16'h0F1D) ^ 16'(o << 4);
        op = (start_w >= 128) ? 8'h0A : 8'h02;
        src_q.push_back(d);
        sb.push_back({op, 8'((start_w * 2) & 255), d});
        if (((o + i + 1) * 2) % 8 == 0) start_w = o + i + 1;
      end
    end
    @(negedge clk);
    offset = 16'(o); count = 16'(c); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    got_done = 1'b0; got_err = 1'b0;
    for (int t = 0; t < 20000 && !got_done && !got_err; t++) begin
      got_done = done;
      got_err  = error;
      if (!got_done && !got_err) @(negedge clk);
    end
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual running expected finished");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    bit dn, er;
    repeat (3) @(negedge clk);
    chk(cs_n && !sck && !mosi && !bus_req && !busy && !wr_ready, "R12", "reset outputs",
        {cs_n, sck, mosi, bus_req, busy, wr_ready}, 6'b100000);
    rst_n = 1'b1;
    @(negedge clk);

    // R9 page split; last word coincides with page boundary
    run(2, 6, 1, dn, er);
    chk(dn && !er, "R11", "done for 2/6", {dn, er}, 2'b10);
    chk(wr_frames == 2, "R9", "write frames 2/6", wr_frames, 2);
    chk(req_rises == 2, "R9", "bus requests 2/6", req_rises, 2);
    chk(wren_cnt == 2, "R5", "enable frames", wren_cnt, 2);
    chk(rdsr_cnt == 2, "R3", "status reads", rdsr_cnt, 2);
    chk(sb.size() == 0, "R8", "words left in scoreboard", sb.size(), 0);
    chk(rd_mosi_bad == 0, "R3", "mosi high during status read", rd_mosi_bad, 0);
    chk(hold_bad == 0, "R10", "mosi change while sck high", hold_bad, 0);
    chk(cs_n && !bus_req && !busy, "R11", "idle after done", {cs_n, bus_req, busy}, 3'b100);

    // R6 extra address bit, R7 address wrap
    run(126, 4, 1, dn, er);
    chk(dn && !er, "R6", "done for 126/4", {dn, er}, 2'b10);
    chk(wr_frames == 2, "R9", "write frames 126/4", wr_frames, 2);
    chk(sb.size() == 0, "R7", "words left", sb.size(), 0);

    // R3 busy status then ready
    busy_left = 3;
    run(40, 1, 1, dn, er);
    chk(dn && !er, "R3", "done after busy polls", {dn, er}, 2'b10);
    chk(rdsr_cnt == 4, "R3", "status reads with 3 busy", rdsr_cnt, 4);
    chk(rd_mosi_bad == 0, "R3", "mosi during reads", rd_mosi_bad, 0);

    // R4 status retry limit
    busy_left = 1000;
    run(10, 2, 0, dn, er);
    chk(er && !dn, "R4", "error on busy part", {dn, er}, 2'b01);
    chk(rdsr_cnt == 8, "R4", "status reads before abort", rdsr_cnt, 8);
    chk(wr_frames == 0 && wren_cnt == 0, "R4", "frames after abort", wr_frames + wren_cnt, 0);
    chk(cs_n && !bus_req, "R4", "released after abort", {cs_n, bus_req}, 2'b10);
    busy_left = 0;

    // R2 grant timeout
    gnt_en = 1'b0;
    run(0, 1, 0, dn, er);
    chk(er && !dn, "R2", "error on grant timeout", {dn, er}, 2'b01);
    chk(frames == 0, "R2", "frames without grant", frames, 0);
    chk(!bus_req && req_rises == 1, "R2", "request dropped", {bus_req, req_rises[0]}, 2'b01);
    gnt_en = 1'b1;

    // R1 bound rejects
    run(256, 1, 0, dn, er);
    chk(er && req_rises == 0, "R1", "offset at size", {er, req_rises[0]}, 2'b10);
    run(0, 0, 0, dn, er);
    chk(er && req_rises == 0, "R1", "zero count", {er, req_rises[0]}, 2'b10);
    run(250, 7, 0, dn, er);
    chk(er && req_rises == 0 && !busy, "R1", "count past end", {er, req_rises[0]}, 2'b10);

    // R1 upper boundary accepted; end of run on page edge
    run(250, 6, 1, dn, er);
    chk(dn && !er, "R1", "exact fit accepted", {dn, er}, 2'b10);
    chk(wr_frames == 2 && req_rises == 2, "R9", "bursts 250/6", wr_frames, 2);
    chk(sb.size() == 0 && src_q.size() == 0, "R8", "all words consumed", sb.size() + src_q.size(), 0);

    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule